// File: doc/BRIEF.md
# Multi-Bank GPIO Controller with Interrupt Detection

This block is a memory-mapped general-purpose I/O controller. Its lines are grouped into banks of up to 32 lines. Each line can drive its pad, either push-pull or open-drain, or act as an input. Every bank owns a window of eight 32-bit registers. These registers hold the pad configuration, the output data, the interrupt mode of each line, the interrupt mask and the interrupt status.

Input pads pass through a two-flop synchronizer. Each line can flag an event on a level or on an edge. Three per-line bit-planes select the mode: level select, edge polarity and both-edge select. A flagged event latches into a sticky status bit, and software clears that bit by writing a 1 to it. A status bit becomes pending when its mask bit is also set. One interrupt output reports a pending line in any bank.

Software reaches the registers through a simple single-cycle port. A write lands on the clock edge. A read returns data combinationally from the current address.

Top module: `gpio_bank_ctl`

## Requirements
- R1: Bank b occupies byte addresses b*32 to b*32+31, and address bits [4:2] select the word in that bank. The word offsets are: 0x00 open-drain enable, 0x04 output data, 0x08 direction, 0x0C edge polarity, 0x10 both-edge select, 0x14 interrupt mask, 0x18 level select, 0x1C status. Every register except status reads back the value written to it.
- R2: After reset the direction register of each bank holds 1 for every implemented line. All other registers, including the mask, hold zero, and `irq` is low.
- R3: A direction bit of 0 makes the line an output, and `pad_oe` is then 1 with `pad_out` equal to the data bit. A direction bit of 1 makes the line an input with `pad_oe` 0. A read of the data word returns the driven data bit for output lines and the synchronized pad value for input lines.
- R4: For an output line whose open-drain bit is 1, a data bit of 0 gives `pad_oe`=1 and `pad_out`=0. A data bit of 1 releases the pad (`pad_oe`=0).
- R5: The per-line mode encoding is (level, polarity, both), and edge events work as follows.
  - (0,0,0) flags a falling edge.
  - (0,1,0) flags a rising edge.
  - (0,x,1) flags either edge.
  - A pad change becomes visible in status, and in `irq` when unmasked, on the third rising clock edge after the change.
- R6: In level mode, (1,0,x) flags a low pad and (1,1,x) flags a high pad. Status is set on every cycle the synchronized pad matches the selected level, so a clear written while the level persists has no effect.
- R7: Writing 1 to a status bit clears it, and writing 0 to a status bit leaves it unchanged. An event in the same cycle as the clear wins.
- R8: `irq` is high exactly while some line in any bank has both its status bit and its mask bit set. A masked event still shows in the status word.
- R9: Lines at or above a bank's configured width (`BANK_LINES`, 6 bits per bank) are inert. Their register bits read 0, they never raise status, and they never drive their pad.
- R10: Addresses whose bank index is at or above `NUM_BANKS` read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, taken on the rising clock edge |
| addr | input | AW (7 by default) | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pad_in | input | NUM_BANKS*32 | Pad input values; line i of bank b is bit b*32+i |
| pad_out | output | NUM_BANKS*32 | Pad output values |
| pad_oe | output | NUM_BANKS*32 | Pad output enables |
| irq | output | 1 | Combined interrupt for all banks |

## Verification
The bound checker watches four properties on every cycle.
- An input line, or a line above the bank width, never drives its pad.
- An open-drain line that holds a 1 never drives.
- A status bit never falls in a cycle with no register write.
- The interrupt is never high while every mask is zero.

The bench covers the behaviour that depends on a sequence of stimulus: the three-edge latency of each edge mode, a clear that has no effect while a level persists, the write-0/write-1 status semantics, readback of the register map with width masking, and the inertness of bank windows that are not implemented.

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl #(
  parameter int NUM_BANKS = 3,
  parameter logic [NUM_BANKS*6-1:0] BANK_LINES = {6'd8, 6'd20, 6'd32},
  localparam int LINES = NUM_BANKS * 32,
  localparam int AW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [LINES-1:0] pad_in,
  output logic [LINES-1:0] pad_out,
  output logic [LINES-1:0] pad_oe,
  output logic             irq
);

  logic [LINES-1:0] sync1_q, sync2_q, prev_q;
  logic [LINES-1:0] valid_v, dir_v, oden_v, data_v, stat_v, mask_v;
  logic [NUM_BANKS-1:0][31:0] rd_all;

  wire [AW-1:0] bidx = addr >> 5;
  wire [2:0]    ridx = addr[4:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int W = int'(BANK_LINES[b*6 +: 6]);
    localparam logic [31:0] VM = (W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << W) - 32'd1);

    logic [31:0] oden_q, data_q, dir_q, pol_q, both_q, mask_q, lvl_q, stat_q;
    logic [31:0] word;

    wire        sel = (bidx == AW'(b));
    wire        hit = wr_en && sel;
    wire [31:0] wd  = wdata & VM;
    wire [31:0] cur = sync2_q[b*32 +: 32];
    wire [31:0] old = prev_q[b*32 +: 32];

    wire [31:0] lvl_hit  = lvl_q & ~(cur ^ pol_q);
    wire [31:0] any_edge = ~lvl_q & both_q & (cur ^ old);
    wire [31:0] rise     = ~lvl_q & ~both_q & pol_q & cur & ~old;
    wire [31:0] fall     = ~lvl_q & ~both_q & ~pol_q & ~cur & old;
    wire [31:0] evt      = VM & (lvl_hit | any_edge | rise | fall);
    wire [31:0] clr      = (hit && ridx == 3'd7) ? wd : 32'd0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        oden_q <= '0;
        data_q <= '0;
        dir_q  <= VM;
        pol_q  <= '0;
        both_q <= '0;
        mask_q <= '0;
        lvl_q  <= '0;
        stat_q <= '0;
      end else begin
        if (hit) begin
          case (ridx)
            3'd0: oden_q <= wd;
            3'd1: data_q <= wd;
            3'd2: dir_q  <= wd;
            3'd3: pol_q  <= wd;
            3'd4: both_q <= wd;
            3'd5: mask_q <= wd;
            3'd6: lvl_q  <= wd;
            default: ;
          endcase
        end
        stat_q <= (stat_q & ~clr) | evt;
      end
    end

    always_comb begin
      case (ridx)
        3'd0: word = oden_q;
        3'd1: word = VM & ((dir_q & cur) | (~dir_q & data_q));
        3'd2: word = dir_q;
        3'd3: word = pol_q;
        3'd4: word = both_q;
        3'd5: word = mask_q;
        3'd6: word = lvl_q;
        default: word = stat_q;
      endcase
    end

    assign rd_all[b] = sel ? word : 32'd0;

    assign pad_out[b*32 +: 32] = data_q & ~oden_q;
    assign pad_oe[b*32 +: 32]  = VM & ~dir_q & ~(oden_q & data_q);

    assign valid_v[b*32 +: 32] = VM;
    assign dir_v[b*32 +: 32]   = dir_q;
    assign oden_v[b*32 +: 32]  = oden_q;
    assign data_v[b*32 +: 32]  = data_q;
    assign stat_v[b*32 +: 32]  = stat_q;
    assign mask_v[b*32 +: 32]  = mask_q;
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) rdata = rdata | rd_all[b];
  end

  assign irq = |(stat_v & mask_v);

endmodule

module gpio_bank_ctl_chk #(
  parameter int LINES = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             irq,
  input logic [LINES-1:0] pad_oe,
  input logic [LINES-1:0] valid_v,
  input logic [LINES-1:0] dir_v,
  input logic [LINES-1:0] oden_v,
  input logic [LINES-1:0] data_v,
  input logic [LINES-1:0] stat_v,
  input logic [LINES-1:0] mask_v
);

  a_r3_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & dir_v) == '0);

  a_r4_open_drain_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & oden_v & data_v) == '0);

  a_r9_unused_inert: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | stat_v) & ~valid_v) == '0);

  a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((stat_v & $past(stat_v)) == $past(stat_v)));

  a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_v != '0));

endmodule

bind gpio_bank_ctl gpio_bank_ctl_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq(irq), .pad_oe(pad_oe),
  .valid_v(valid_v), .dir_v(dir_v), .oden_v(oden_v), .data_v(data_v),
  .stat_v(stat_v), .mask_v(mask_v)
);

// File: tb/test_gpio_bank_ctl.sv
module test_gpio_bank_ctl;

  localparam int LINES = 96;
  localparam int AW = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic [LINES-1:0] pad_in = '0;
  logic [LINES-1:0] pad_out, pad_oe;
  logic             irq;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  gpio_bank_ctl i_gpio_bank_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  typedef struct packed {
    logic [AW-1:0] a;
    logic [31:0]   d;
    logic [31:0]   e;
  } vec_t;

  localparam vec_t VT[7] = '{
    '{a: 7'h0C, d: 32'hA5A5_A5A5, e: 32'hA5A5_A5A5},
    '{a: 7'h34, d: 32'hFFFF_FFFF, e: 32'h000F_FFFF},
    '{a: 7'h58, d: 32'hFFFF_FFFF, e: 32'h0000_00FF},
    '{a: 7'h40, d: 32'h0000_1234, e: 32'h0000_0034},
    '{a: 7'h30, d: 32'h0000_F00F, e: 32'h0000_F00F},
    '{a: 7'h28, d: 32'h0000_0F0F, e: 32'h0000_0F0F},
    '{a: 7'h70, d: 32'hFFFF_FFFF, e: 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    pad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a;
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();

    chk("R2 irq after reset", {31'd0, irq}, 32'd0);
    rd(7'h08, v); chk("R2 bank0 dir reset", v, 32'hFFFF_FFFF);
    rd(7'h28, v); chk("R2 bank1 dir reset", v, 32'h000F_FFFF);
    rd(7'h48, v); chk("R2 bank2 dir reset", v, 32'h0000_00FF);
    rd(7'h14, v); chk("R2 mask reset", v, 32'd0);
    chk("R2 pad_oe reset", 32'(|pad_oe), 32'd0);

    foreach (VT[k]) begin
      wr(VT[k].a, VT[k].d);
      rd(VT[k].a, v);
      chk($sformatf("R1 table entry %0d", k), v, VT[k].e);
    end

    do_reset();
    wr(7'h08, 32'hFFFF_FFFE);
    wr(7'h04, 32'h1);
    chk("R3 output enable", pad_oe[31:0], 32'h1);
    chk("R3 output value", {31'd0, pad_out[0]}, 32'h1);
    pad_in[1] = 1'b1;
    repeat (2) @(negedge clk);
    rd(7'h04, v); chk("R3 data read mix", v, 32'h3);
    wr(7'h00, 32'h1);
    chk("R4 open drain released", pad_oe[31:0], 32'h0);
    wr(7'h04, 32'h0);
    chk("R4 open drain drive low", pad_oe[31:0], 32'h1);
    chk("R4 open drain low value", {31'd0, pad_out[0]}, 32'h0);

    do_reset();
    wr(7'h2C, 32'h8);
    wr(7'h34, 32'h8);
    pad_in[35] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 rising not yet", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R5 rising third edge", {31'd0, irq}, 32'd1);
    rd(7'h3C, v); chk("R5 rising status", v, 32'h8);
    wr(7'h3C, 32'h0);
    rd(7'h3C, v); chk("R7 write zero keeps", v, 32'h8);
    wr(7'h3C, 32'h8);
    rd(7'h3C, v); chk("R7 write one clears", v, 32'h0);
    chk("R8 irq drops", {31'd0, irq}, 32'd0);
    pad_in[35] = 1'b0;
    repeat (4) @(negedge clk);
    rd(7'h3C, v); chk("R5 rising ignores fall", v, 32'h0);

    pad_in[5] = 1'b1;
    repeat (4) @(negedge clk);
    rd(7'h1C, v); chk("R5 falling ignores rise", v, 32'h0);
    pad_in[5] = 1'b0;
    repeat (4) @(negedge clk);
    rd(7'h1C, v); chk("R5 falling status", v, 32'h20);
    chk("R8 masked no irq", {31'd0, irq}, 32'd0);
    wr(7'h14, 32'h20);
    chk("R8 unmask irq", {31'd0, irq}, 32'd1);

    do_reset();
    wr(7'h50, 32'h2);
    pad_in[65] = 1'b1;
    repeat (4) @(negedge clk);
    rd(7'h5C, v); chk("R5 both rise", v, 32'h2);
    wr(7'h5C, 32'h2);
    pad_in[65] = 1'b0;
    repeat (4) @(negedge clk);
    rd(7'h5C, v); chk("R5 both fall", v, 32'h2);

    do_reset();
    wr(7'h0C, 32'h80);
    wr(7'h18, 32'h80);
    rd(7'h1C, v); chk("R6 level high idle", v, 32'h0);
    pad_in[7] = 1'b1;
    repeat (3) @(negedge clk);
    rd(7'h1C, v); chk("R6 level high set", v, 32'h80);
    wr(7'h1C, 32'h80);
    rd(7'h1C, v); chk("R6 clear while active", v, 32'h80);
    pad_in[7] = 1'b0;
    repeat (3) @(negedge clk);
    wr(7'h1C, 32'h80);
    rd(7'h1C, v); chk("R6 clear after level gone", v, 32'h0);

    do_reset();
    wr(7'h38, 32'h1);
    @(negedge clk);
    rd(7'h3C, v); chk("R6 level low set", v, 32'h1);

    do_reset();
    wr(7'h38, 32'h0200_0000);
    rd(7'h38, v); chk("R9 unused level bit", v, 32'h0);
    repeat (3) @(negedge clk);
    rd(7'h3C, v); chk("R9 unused no status", v, 32'h0);
    wr(7'h48, 32'h0);
    chk("R9 bank2 drive limited", pad_oe[95:64], 32'h0000_00FF);

    wr(7'h74, 32'hFFFF_FFFF);
    rd(7'h74, v); chk("R10 missing bank mask", v, 32'h0);
    rd(7'h60, v); chk("R10 missing bank read", v, 32'h0);
    chk("R10 no irq", {31'd0, irq}, 32'd0);

    summary();
    $finish;
  end

endmodule